// File: doc/BRIEF.md
# Physical Address Hole-Remap and Interleave Decoder

This block turns a system physical address into a DRAM location: a branch, a rank and a line index within that rank. Just below the 4 GB boundary it keeps an address window for memory-mapped I/O. The window always ends at the boundary, and a configuration input picks its lower edge in steps of one quarter of the boundary.

Installed DRAM that the window would hide is not lost. Whenever the installed size is larger than the window's start, the block moves that DRAM to addresses that begin at the 4 GB boundary, with no enable bit. Successive 64-byte cache lines alternate between two branches. Inside a branch they rotate over four ranks, where each rank is a lockstepped pair of single-rank modules.

The decode takes one registered stage. Each accepted address produces exactly one of three results: DRAM hit, MMIO hit or unmapped.

Top module: `hole_remap_decoder`

## Requirements
- R1: The MMIO window covers [S, B), where B is the 4 GB boundary (2^BOUND_LOG2). Its start S is `hole_sel` times B/4 for codes 1, 2 and 3, and code 0 selects the default of 2·B/4. Every address inside the window reports `mmio_hit` and no DRAM hit.
- R2: An address below S that is also below the installed size M (M = `mem_units`·B/4) is a DRAM hit with DRAM address equal to the input address.
- R3: An address below S that is at or above M reports `unmapped`.
- R4: When M > S, addresses in [B, B + M − S) are DRAM hits with DRAM address = address − B + S.
- R5: An address at or above B that lies outside the reclaimed range reports `unmapped`. When M ≤ S, this covers every such address.
- R6: `out_branch` is bit 6 of the DRAM address, so consecutive 64-byte lines alternate between branches.
- R7: `out_rank` is bits 8:7 of the DRAM address and `out_line` is the DRAM address bits above bit 8. Both fields, and `out_branch`, read zero unless `dram_hit` is set.
- R8: `out_valid` equals `in_valid` one clock earlier. When `out_valid` is set, exactly one of `dram_hit`, `mmio_hit` and `unmapped` is set.
- R9: When `out_valid` is low, all flags and all fields are zero.
- R10: While `rst_n` is low at a clock edge, all outputs are cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Address strobe |
| in_addr | input | ADDR_W | System physical address |
| hole_sel | input | 2 | Window start code: 0 selects the default 2/4 of B; 1, 2 and 3 select that many quarters of B |
| mem_units | input | MEM_W | Installed DRAM size in units of B/4 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| dram_hit | output | 1 | Address maps to DRAM |
| mmio_hit | output | 1 | Address lies in the MMIO window |
| unmapped | output | 1 | Address maps to nothing |
| out_branch | output | BRANCH_BITS | Branch select |
| out_rank | output | RANK_BITS | Rank within the branch |
| out_line | output | ADDR_W−9 | Line index within the rank |

## Verification
On every cycle, the assertions check the strobe timing and that exactly one result flag is set. They also check that idle outputs stay quiet, that any address inside the window reports MMIO, and that addresses above the boundary are unmapped when no reclaim applies. Only the bench's sweeps can show that the reclaim offset is correct and that the window edges fall on the right quarter for each code. The sweeps also confirm the default for code 0 and the branch and rank rotation of consecutive lines. To do this they walk every hole code across a range of installed sizes and compare against an arithmetic model.

// File: rtl/hole_remap_pkg.sv
// Package: shared types and helpers for the hole-remap decoder.
// Assumes the window start is expressed in quarters of the boundary.
package hole_remap_pkg;

    // Result class of one decoded address.
    typedef enum logic [1:0] {
        RGN_UNMAP = 2'd0,
        RGN_DRAM  = 2'd1,
        RGN_MMIO  = 2'd2
    } region_e;

    // Converts a window code into the number of boundary quarters below the window.
    function automatic logic [1:0] start_quarters(input logic [1:0] code);
        return (code == 2'd0) ? 2'd2 : code;
    endfunction

endpackage

// File: rtl/hole_window.sv
// hole_window: converts the window code into the window start address.
// Assumes the window ends at 2^BOUND_LOG2 and starts on a quarter of it.
module hole_window
    import hole_remap_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int BOUND_LOG2 = 32
) (
    input  logic [1:0]      hole_sel,
    output logic [ADDR_W:0] hole_start
);
    localparam int QLOG2 = BOUND_LOG2 - 2;

    // Scale the quarter count to a byte address.
    always_comb begin
        hole_start = (ADDR_W + 1)'(start_quarters(hole_sel)) << QLOG2;
    end
endmodule

// File: rtl/region_map.sv
// region_map: classifies an address as DRAM, MMIO or unmapped and computes
// the DRAM address, applying the reclaim offset above the boundary.
// Assumes hole_start < boundary; DRAM address is zero unless class is DRAM.
module region_map
    import hole_remap_pkg::*;
#(
    parameter int ADDR_W     = 40,
    parameter int BOUND_LOG2 = 32,
    parameter int MEM_W      = 11
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W:0]   hole_start,
    input  logic [MEM_W-1:0]  mem_units,
    output region_e           region,
    output logic [ADDR_W-1:0] dram_addr
);
    localparam int W1    = ADDR_W + 1;
    localparam int QLOG2 = BOUND_LOG2 - 2;
    localparam logic [W1-1:0] BOUND = {{(W1-1){1'b0}}, 1'b1} << BOUND_LOG2;

    logic [W1-1:0] a_ext;
    logic [W1-1:0] mem_bytes;
    logic [W1-1:0] reclaim_len;
    logic [W1-1:0] above_off;
    logic [W1-1:0] remapped;
    logic          reclaim_on;

    // Derive extended operands and the reclaim window length.
    always_comb begin
        a_ext       = {1'b0, addr};
        mem_bytes   = W1'(mem_units) << QLOG2;
        reclaim_on  = mem_bytes > hole_start;
        reclaim_len = reclaim_on ? (mem_bytes - hole_start) : '0;
        above_off   = a_ext - BOUND;
        remapped    = above_off + hole_start;
    end

    // Choose the region and the DRAM address for it.
    always_comb begin
        region    = RGN_UNMAP;
        dram_addr = '0;
        if (a_ext < hole_start) begin
            if (a_ext < mem_bytes) begin
                region    = RGN_DRAM;
                dram_addr = addr;
            end
        end else if (a_ext < BOUND) begin
            region = RGN_MMIO;
        end else if (reclaim_on && (above_off < reclaim_len)) begin
            region    = RGN_DRAM;
            dram_addr = remapped[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/line_interleave.sv
// line_interleave: splits a DRAM address into branch, rank and line index.
// Assumes lines of 2^LINE_LOG2 bytes; branch bits sit just above the byte
// offset, rank bits above those, and the rest forms the line index.
module line_interleave #(
    parameter int ADDR_W      = 40,
    parameter int LINE_LOG2   = 6,
    parameter int BRANCH_BITS = 1,
    parameter int RANK_BITS   = 2,
    localparam int LINE_IDX_W = ADDR_W - LINE_LOG2 - BRANCH_BITS - RANK_BITS
) (
    input  logic [ADDR_W-1:0]      dram_addr,
    output logic [BRANCH_BITS-1:0] branch,
    output logic [RANK_BITS-1:0]   rank,
    output logic [LINE_IDX_W-1:0]  line_idx
);
    localparam int BR_LSB   = LINE_LOG2;
    localparam int RK_LSB   = LINE_LOG2 + BRANCH_BITS;
    localparam int LINE_LSB = RK_LSB + RANK_BITS;

    logic unused_offset;

    // Byte offset within a line does not select any resource.
    assign unused_offset = ^dram_addr[LINE_LOG2-1:0];

    // Slice each interleave field bit by bit.
    for (genvar i = 0; i < BRANCH_BITS; i++) begin : g_branch
        assign branch[i] = dram_addr[BR_LSB + i];
    end
    for (genvar i = 0; i < RANK_BITS; i++) begin : g_rank
        assign rank[i] = dram_addr[RK_LSB + i];
    end
    assign line_idx = dram_addr[ADDR_W-1:LINE_LSB];
endmodule

// File: rtl/hole_remap_decoder.sv
// hole_remap_decoder: top level. Decodes a physical address through the MMIO
// window, reclaim remap and branch/rank interleave, with one register stage.
// Assumes hole_sel and mem_units are stable while addresses are presented.
module hole_remap_decoder
    import hole_remap_pkg::*;
#(
    parameter int ADDR_W      = 40,
    parameter int BOUND_LOG2  = 32,
    parameter int LINE_LOG2   = 6,
    parameter int BRANCH_BITS = 1,
    parameter int RANK_BITS   = 2,
    localparam int MEM_W      = ADDR_W - BOUND_LOG2 + 3,
    localparam int LINE_IDX_W = ADDR_W - LINE_LOG2 - BRANCH_BITS - RANK_BITS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [ADDR_W-1:0]      in_addr,
    input  logic [1:0]             hole_sel,
    input  logic [MEM_W-1:0]       mem_units,
    output logic                   out_valid,
    output logic                   dram_hit,
    output logic                   mmio_hit,
    output logic                   unmapped,
    output logic [BRANCH_BITS-1:0] out_branch,
    output logic [RANK_BITS-1:0]   out_rank,
    output logic [LINE_IDX_W-1:0]  out_line
);
    localparam int QLOG2 = BOUND_LOG2 - 2;
    localparam logic [ADDR_W:0] BOUND = {{ADDR_W{1'b0}}, 1'b1} << BOUND_LOG2;

    logic [ADDR_W:0]        hole_start;
    region_e                region;
    logic [ADDR_W-1:0]      dram_addr;
    logic [BRANCH_BITS-1:0] nx_branch;
    logic [RANK_BITS-1:0]   nx_rank;
    logic [LINE_IDX_W-1:0]  nx_line;

    hole_window #(.ADDR_W(ADDR_W), .BOUND_LOG2(BOUND_LOG2)) u_window (
        .hole_sel  (hole_sel),
        .hole_start(hole_start)
    );

    region_map #(.ADDR_W(ADDR_W), .BOUND_LOG2(BOUND_LOG2), .MEM_W(MEM_W)) u_region (
        .addr      (in_addr),
        .hole_start(hole_start),
        .mem_units (mem_units),
        .region    (region),
        .dram_addr (dram_addr)
    );

    line_interleave #(
        .ADDR_W(ADDR_W), .LINE_LOG2(LINE_LOG2),
        .BRANCH_BITS(BRANCH_BITS), .RANK_BITS(RANK_BITS)
    ) u_split (
        .dram_addr(dram_addr),
        .branch   (nx_branch),
        .rank     (nx_rank),
        .line_idx (nx_line)
    );

    // Output stage: capture the decode on a valid strobe, else go quiet.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_valid) begin
            out_valid  <= 1'b0;
            dram_hit   <= 1'b0;
            mmio_hit   <= 1'b0;
            unmapped   <= 1'b0;
            out_branch <= '0;
            out_rank   <= '0;
            out_line   <= '0;
        end else begin
            out_valid  <= 1'b1;
            dram_hit   <= (region == RGN_DRAM);
            mmio_hit   <= (region == RGN_MMIO);
            unmapped   <= (region == RGN_UNMAP);
            out_branch <= nx_branch;
            out_rank   <= nx_rank;
            out_line   <= nx_line;
        end
    end

    // R8: result strobe tracks the input strobe one cycle later.
    a_r8_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R8: a valid result carries exactly one class flag.
    a_r8_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({dram_hit, mmio_hit, unmapped}) == 1));
    // R9: idle cycles drive nothing.
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!dram_hit && !mmio_hit && !unmapped &&
                        out_branch == '0 && out_rank == '0 && out_line == '0));
    // R7: fields stay zero without a DRAM hit.
    a_r7_fields_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_hit |-> (out_branch == '0 && out_rank == '0 && out_line == '0));
    // R1: any strobed address inside the window is an MMIO hit next cycle.
    a_r1_window_mmio: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && {1'b0, in_addr} >= hole_start && {1'b0, in_addr} < BOUND)
        |=> mmio_hit);
    // R5: without reclaim, everything above the boundary is unmapped.
    a_r5_no_reclaim: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && {1'b0, in_addr} >= BOUND &&
         ((ADDR_W + 1)'(mem_units) << QLOG2) <= hole_start)
        |=> unmapped);
endmodule

// File: tb/sim_hole_remap_decoder.sv
`timescale 1ns/1ps
module sim_hole_remap_decoder;
    localparam int AW = 14;
    localparam int BL = 12;
    localparam int MW = AW - BL + 3;
    localparam int LW = AW - 9;
    localparam int Q  = 1 << (BL - 2);
    localparam int B  = 1 << BL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] in_addr = '0;
    logic [1:0]    hole_sel = 2'd0;
    logic [MW-1:0] mem_units = '0;
    logic          out_valid, dram_hit, mmio_hit, unmapped;
    logic [0:0]    out_branch;
    logic [1:0]    out_rank;
    logic [LW-1:0] out_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hole_remap_decoder #(.ADDR_W(AW), .BOUND_LOG2(BL)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .hole_sel(hole_sel), .mem_units(mem_units), .out_valid(out_valid),
        .dram_hit(dram_hit), .mmio_hit(mmio_hit), .unmapped(unmapped),
        .out_branch(out_branch), .out_rank(out_rank), .out_line(out_line)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Packs all outputs into one integer for comparison.
    function automatic int pack_out();
        return {out_valid, dram_hit, mmio_hit, unmapped, out_branch, out_rank, out_line};
    endfunction

    function automatic int pack_exp(int v, int d, int m, int u, int da);
        int br, rk, ln;
        br = d ? (da >> 6) & 1 : 0;
        rk = d ? (da >> 7) & 3 : 0;
        ln = d ? (da >> 9) : 0;
        return (v << (LW + 6)) | (d << (LW + 5)) | (m << (LW + 4)) | (u << (LW + 3)) |
               (br << (LW + 2)) | (rk << LW) | ln;
    endfunction

    // Drives one address and compares the registered result one cycle later.
    task automatic probe(input int sel, input int mu, input int a);
        int start, mem, d, m, u, da;
        string tag;
        start = ((sel == 0) ? 2 : sel) * Q;
        mem   = mu * Q;
        d = 0; m = 0; u = 0; da = 0;
        if (a < start) begin
            if (a < mem) begin d = 1; da = a; tag = "R2 R6 R7 R8"; end
            else begin u = 1; tag = "R3 R8"; end
        end else if (a < B) begin
            m = 1; tag = "R1 R8";
        end else if (mem > start && (a - B) < (mem - start)) begin
            d = 1; da = a - B + start; tag = "R4 R6 R7 R8";
        end else begin
            u = 1; tag = "R5 R8";
        end
        @(negedge clk);
        hole_sel  = 2'(sel);
        mem_units = MW'(mu);
        in_addr   = AW'(a);
        in_valid  = 1'b1;
        @(negedge clk);
        check(tag, pack_out(), pack_exp(1, d, m, u, da));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs cleared under reset.
        check("R10 reset", pack_out(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", pack_out(), 0);

        for (int sel = 0; sel < 4; sel++)
            for (int mu = 0; mu <= 16; mu++)
                for (int a = 0; a < (1 << AW); a += 32)
                    probe(sel, mu, a);

        // Window edges for the default code (R1, R2, R3).
        probe(0, 16, 2 * Q - 1);
        probe(0, 16, 2 * Q);
        probe(0, 16, B - 1);
        probe(3, 2, 2 * Q - 1);
        // Reclaim boundary (R4, R5).
        probe(1, 6, B + 5 * Q - 1);
        probe(1, 6, B + 5 * Q);

        // R9: strobe low yields quiet outputs even for a mappable address.
        @(negedge clk);
        in_valid = 1'b0;
        in_addr  = AW'(64);
        @(negedge clk);
        check("R9 idle output", pack_out(), 0);
        check("R8 strobe drop", int'(out_valid), 0);

        // R10: reset in the middle of traffic.
        in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 mid reset", pack_out(), 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule